// File: doc/BRIEF.md
# Vector compare and condition unit

This block executes the comparison-style instructions of a vector shader pipeline. Each operation takes two four-lane source vectors that have already been swizzled. The lanes hold 24-bit floating-point values: bit 23 is the sign, bits 22:16 are a 7-bit exponent with bias 63, and bits 15:0 are a 16-bit mantissa with a hidden leading one. Lane i of a source bus sits at bits [24*i+23 : 24*i].

A two-bit form code chooses what one operation does:

| Code | Form | Effect |
|------|------|--------|
| 0 | set-if-greater-or-equal | writes 1.0 or 0.0 into each enabled lane |
| 1 | set-if-less-than | writes 1.0 or 0.0 into each enabled lane |
| 2 | compare | updates the two condition bits, each with its own operator |
| 3 | address load | truncates lanes 0 and 1 to signed integers and writes them into the two address registers |

Branching on the condition bits happens in the sequencer and is not part of this block. Every result is registered, and it appears one clock after the valid input.

Top module: `vcmp_unit`

## Requirements
- R1: When in_valid is high with form 0, each lane enabled in in_mask shows, one clock later on out_vec, 1.0 (24'h3F0000) if src1 >= src2, and otherwise 0.0 (24'h000000).
- R2: When in_valid is high with form 1, each enabled lane shows 1.0 if src1 < src2, and otherwise 0.0, one clock later.
- R3: For forms 0 and 1, out_wen equals in_mask (bit i is lane i). For forms 2 and 3, and on idle cycles, out_wen is 0. A lane whose out_wen bit is low reads 0 on out_vec.
- R4: Ordering follows sign-magnitude rules on the 24-bit format, and +0 and -0 compare as equal.
- R5: Form 2 applies operator in_opx to lane 0 and writes the result into cond[0]. It applies in_opy to lane 1 and writes the result into cond[1]. The operator codes are 0 equal, 1 not equal, 2 less than, 3 less or equal, 4 greater than, 5 greater or equal.
- R6: An operator code of 6 or 7 leaves its condition bit unchanged. Such a code also makes bad_op high for one cycle, together with out_valid.
- R7: Form 3 converts a lane to a signed ADDR_W-bit integer by truncation toward zero. The result saturates at the largest and smallest values of the register.
- R8: Form 3 writes addr_x only when in_mask[0] is set and addr_y only when in_mask[1] is set. Mask bits 2 and 3 have no effect.
- R9: The condition bits change only on a valid form-2 input, and the address registers change only on a valid form-3 input.
- R10: out_valid follows in_valid with one clock of delay. Reset (rst_n low, asynchronous) clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_form | input | 2 | Form code: 0 set-ge, 1 set-lt, 2 compare, 3 address load |
| in_mask | input | LANES (4) | Lane write mask |
| in_opx | input | 3 | Compare operator for lane 0 / cond[0] |
| in_opy | input | 3 | Compare operator for lane 1 / cond[1] |
| in_src1 | input | LANES*24 (96) | First source vector |
| in_src2 | input | LANES*24 (96) | Second source vector |
| out_valid | output | 1 | Registered result valid |
| out_wen | output | LANES (4) | Per-lane destination write strobe |
| out_vec | output | LANES*24 (96) | Destination vector value |
| cond | output | 2 | Condition bits |
| addr_x | output | ADDR_W (8) | Address register 0 |
| addr_y | output | ADDR_W (8) | Address register 1 |
| bad_op | output | 1 | Unknown compare operator seen |

## Verification
The bench uses the default parameters: four lanes, a 7/16 float split and eight-bit address registers. With eight-bit address registers, both saturation ends are reached by values of only a few hundred, so random exponents between 2^-5 and 2^8 cover the zero result, the in-range results and both clamps in one run. The same range keeps lane pairs close enough together that equal values, signed zeros and sign-crossing pairs occur often, alongside all 64 pairs of compare operators.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

    typedef enum logic [1:0] {
        FORM_SGE  = 2'd0,
        FORM_SLT  = 2'd1,
        FORM_CMP  = 2'd2,
        FORM_ADDR = 2'd3
    } form_e;

    typedef enum logic [2:0] {
        REL_EQ = 3'd0,
        REL_NE = 3'd1,
        REL_LT = 3'd2,
        REL_LE = 3'd3,
        REL_GT = 3'd4,
        REL_GE = 3'd5
    } relop_e;

    localparam int NUM_COND = 2;

endpackage

// File: rtl/vcmp_lane_order.sv
// Sign-magnitude ordering of two packed floats; both zeros are equal.
module vcmp_lane_order #(
    parameter int EXP_W = 7,
    parameter int MAN_W = 16
) (
    input  logic [EXP_W+MAN_W:0] a,
    input  logic [EXP_W+MAN_W:0] b,
    output logic                 lt,
    output logic                 eq
);
    localparam int FP_W = 1 + EXP_W + MAN_W;

    logic               sa, sb;
    logic [FP_W-2:0]    ma, mb;
    logic               za, zb;

    always_comb begin
        sa = a[FP_W-1];
        sb = b[FP_W-1];
        ma = a[FP_W-2:0];
        mb = b[FP_W-2:0];
        za = (ma == '0);
        zb = (mb == '0);
        eq = (za && zb) || (a == b);
        if (za && zb) begin
            lt = 1'b0;
        end else if (sa != sb) begin
            lt = sa;
        end else if (sa) begin
            lt = (ma > mb);
        end else begin
            lt = (ma < mb);
        end
    end
endmodule

// File: rtl/vcmp_to_int.sv
// Truncating float-to-signed-integer conversion with saturation.
module vcmp_to_int #(
    parameter int EXP_W = 7,
    parameter int MAN_W = 16,
    parameter int OUT_W = 8
) (
    input  logic [EXP_W+MAN_W:0] x,
    output logic [OUT_W-1:0]     y
);
    localparam int                FP_W   = 1 + EXP_W + MAN_W;
    localparam int                BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam logic [EXP_W-1:0]  BIAS_V = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0]  SAT_E  = EXP_W'(OUT_W - 1);
    localparam logic [EXP_W-1:0]  MAN_V  = EXP_W'(MAN_W);

    logic               sgn;
    logic [EXP_W-1:0]   ex;
    logic [EXP_W-1:0]   up;
    logic [MAN_W:0]     sig;
    logic [OUT_W-1:0]   mag;

    always_comb begin
        sgn = x[FP_W-1];
        ex  = x[FP_W-2:MAN_W];
        sig = {1'b1, x[MAN_W-1:0]};
        up  = ex - BIAS_V;
        mag = '0;
        y   = '0;
        if (ex < BIAS_V) begin
            y = '0;
        end else if (up >= SAT_E) begin
            y = sgn ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
        end else begin
            mag = OUT_W'(sig >> (MAN_V - up));
            y   = sgn ? (~mag + 1'b1) : mag;
        end
    end
endmodule

// File: rtl/vcmp_relop.sv
// Decodes one three-bit compare operator against an ordering result.
module vcmp_relop
    import vcmp_pkg::*;
(
    input  logic [2:0] op,
    input  logic       lt,
    input  logic       eq,
    output logic       hit,
    output logic       known
);
    always_comb begin
        known = 1'b1;
        hit   = 1'b0;
        case (relop_e'(op))
            REL_EQ:  hit = eq;
            REL_NE:  hit = !eq;
            REL_LT:  hit = lt;
            REL_LE:  hit = lt || eq;
            REL_GT:  hit = !lt && !eq;
            REL_GE:  hit = !lt;
            default: known = 1'b0;
        endcase
    end
endmodule

// File: rtl/vcmp_unit.sv
module vcmp_unit
    import vcmp_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int EXP_W  = 7,
    parameter int MAN_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [1:0]                    in_form,
    input  logic [LANES-1:0]              in_mask,
    input  logic [2:0]                    in_opx,
    input  logic [2:0]                    in_opy,
    input  logic [LANES*(1+EXP_W+MAN_W)-1:0] in_src1,
    input  logic [LANES*(1+EXP_W+MAN_W)-1:0] in_src2,
    output logic                          out_valid,
    output logic [LANES-1:0]              out_wen,
    output logic [LANES*(1+EXP_W+MAN_W)-1:0] out_vec,
    output logic [1:0]                    cond,
    output logic [ADDR_W-1:0]             addr_x,
    output logic [ADDR_W-1:0]             addr_y,
    output logic                          bad_op
);
    localparam int FP_W = 1 + EXP_W + MAN_W;
    localparam logic [FP_W-1:0] FP_ONE  = {2'b00, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};
    localparam logic [FP_W-1:0] FP_ZERO = '0;

    typedef struct packed {
        logic                          vld;
        logic [LANES-1:0]              wen;
        logic [LANES-1:0][FP_W-1:0]    vec;
        logic [NUM_COND-1:0]           cc;
        logic [ADDR_W-1:0]             ax;
        logic [ADDR_W-1:0]             ay;
        logic                          bad;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0]       lane_lt;
    logic [LANES-1:0]       lane_eq;
    logic [NUM_COND-1:0]    rel_hit;
    logic [NUM_COND-1:0]    rel_known;
    logic [ADDR_W-1:0]      conv [NUM_COND];

    // Per-lane ordering
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vcmp_lane_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) order_i (
            .a  (in_src1[g*FP_W +: FP_W]),
            .b  (in_src2[g*FP_W +: FP_W]),
            .lt (lane_lt[g]),
            .eq (lane_eq[g])
        );
    end

    // Condition operators and integer converters for lanes 0 and 1
    for (genvar c = 0; c < NUM_COND; c++) begin : g_cc
        vcmp_relop rel_i (
            .op    (c == 0 ? in_opx : in_opy),
            .lt    (lane_lt[c]),
            .eq    (lane_eq[c]),
            .hit   (rel_hit[c]),
            .known (rel_known[c])
        );
        vcmp_to_int #(.EXP_W(EXP_W), .MAN_W(MAN_W), .OUT_W(ADDR_W)) cvt_i (
            .x (in_src1[c*FP_W +: FP_W]),
            .y (conv[c])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.wen = '0;
        st_d.vec = '0;
        st_d.bad = 1'b0;
        if (in_valid) begin
            case (form_e'(in_form))
                FORM_SGE, FORM_SLT: begin
                    for (int i = 0; i < LANES; i++) begin
                        if (in_mask[i]) begin
                            st_d.wen[i] = 1'b1;
                            if (in_form == FORM_SGE) begin
                                st_d.vec[i] = (lane_eq[i] || !lane_lt[i]) ? FP_ONE : FP_ZERO;
                            end else begin
                                st_d.vec[i] = lane_lt[i] ? FP_ONE : FP_ZERO;
                            end
                        end
                    end
                end
                FORM_CMP: begin
                    for (int c = 0; c < NUM_COND; c++) begin
                        if (rel_known[c]) begin
                            st_d.cc[c] = rel_hit[c];
                        end else begin
                            st_d.bad = 1'b1;
                        end
                    end
                end
                FORM_ADDR: begin
                    if (in_mask[0]) st_d.ax = conv[0];
                    if (in_mask[1]) st_d.ay = conv[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_wen   = st_q.wen;
    assign out_vec   = st_q.vec;
    assign cond      = st_q.cc;
    assign addr_x    = st_q.ax;
    assign addr_y    = st_q.ay;
    assign bad_op    = st_q.bad;

endmodule

// File: rtl/vcmp_unit_chk.sv
module vcmp_unit_chk #(
    parameter int LANES  = 4,
    parameter int EXP_W  = 7,
    parameter int MAN_W  = 16,
    parameter int ADDR_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic [1:0]                    in_form,
    input logic [LANES-1:0]              in_mask,
    input logic [2:0]                    in_opx,
    input logic [2:0]                    in_opy,
    input logic                          out_valid,
    input logic [LANES-1:0]              out_wen,
    input logic [LANES*(1+EXP_W+MAN_W)-1:0] out_vec,
    input logic [1:0]                    cond,
    input logic [ADDR_W-1:0]             addr_x,
    input logic [ADDR_W-1:0]             addr_y,
    input logic                          bad_op
);
    localparam int FP_W = 1 + EXP_W + MAN_W;
    localparam logic [FP_W-1:0] FP_ONE = {2'b00, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};

    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r3_set_wen: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_form[1]) |=> (out_wen == $past(in_mask)));
    a_r3_other_wen: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid || in_form[1]) |=> (out_wen == '0));
    a_r9_cond_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cond) |-> $past(in_valid && in_form == 2'd2));
    a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(addr_x) || !$stable(addr_y)) |-> $past(in_valid && in_form == 2'd3));
    a_r8_mask_x: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_x) |-> $past(in_mask[0]));
    a_r8_mask_y: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_y) |-> $past(in_mask[1]));
    a_r6_bad_src: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |-> (out_valid && $past(in_form == 2'd2 && (in_opx > 3'd5 || in_opy > 3'd5))));
    a_r6_keep_x: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_form == 2'd2 && in_opx > 3'd5) |=> $stable(cond[0]));
    a_r6_keep_y: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_form == 2'd2 && in_opy > 3'd5) |=> $stable(cond[1]));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        a_r1_levels: assert property (@(posedge clk) disable iff (!rst_n)
            out_wen[g] |-> (out_vec[g*FP_W +: FP_W] == FP_ONE || out_vec[g*FP_W +: FP_W] == '0));
        a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !out_wen[g] |-> (out_vec[g*FP_W +: FP_W] == '0));
    end
endmodule

bind vcmp_unit vcmp_unit_chk #(
    .LANES(LANES), .EXP_W(EXP_W), .MAN_W(MAN_W), .ADDR_W(ADDR_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_form(in_form),
    .in_mask(in_mask), .in_opx(in_opx), .in_opy(in_opy),
    .out_valid(out_valid), .out_wen(out_wen), .out_vec(out_vec),
    .cond(cond), .addr_x(addr_x), .addr_y(addr_y), .bad_op(bad_op)
);

// File: tb/vcmp_unit_tb.sv
module vcmp_unit_tb_top;
    localparam int CLK_P = 10;
    localparam int AW    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_form = '0;
    logic [3:0]  in_mask = '0;
    logic [2:0]  in_opx = '0, in_opy = '0;
    logic [95:0] in_src1 = '0, in_src2 = '0;
    logic        out_valid;
    logic [3:0]  out_wen;
    logic [95:0] out_vec;
    logic [1:0]  cond;
    logic [AW-1:0] addr_x, addr_y;
    logic        bad_op;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [1:0]    m_cond = '0;
    logic [AW-1:0] m_ax = '0, m_ay = '0;

    always #(CLK_P/2) clk = ~clk;

    vcmp_unit #(.LANES(4), .EXP_W(7), .MAN_W(16), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_form(in_form),
        .in_mask(in_mask), .in_opx(in_opx), .in_opy(in_opy),
        .in_src1(in_src1), .in_src2(in_src2), .out_valid(out_valid),
        .out_wen(out_wen), .out_vec(out_vec), .cond(cond),
        .addr_x(addr_x), .addr_y(addr_y), .bad_op(bad_op)
    );

    task automatic chk(input string tag, input logic [95:0] got, input logic [95:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic real f2r(input logic [23:0] x);
        real m;
        if (x[22:0] == 0) return 0.0;
        m = 1.0 + real'(int'(x[15:0])) / 65536.0;
        m = m * (2.0 ** (real'(int'(x[22:16])) - 63.0));
        return x[23] ? -m : m;
    endfunction

    function automatic int to_i(input real r);
        if (r >= 2.0 ** (AW - 1)) return (2 ** (AW - 1)) - 1;
        if (r <= -(2.0 ** (AW - 1))) return -(2 ** (AW - 1));
        return $rtoi(r);
    endfunction

    function automatic bit relop(input int op, input real a, input real b);
        case (op)
            0: return a == b;
            1: return a != b;
            2: return a < b;
            3: return a <= b;
            4: return a > b;
            default: return a >= b;
        endcase
    endfunction

    function automatic logic [95:0] v4(input logic [23:0] l0, l1, l2, l3);
        return {l3, l2, l1, l0};
    endfunction

    function automatic logic [23:0] rnd_fp();
        logic s;
        s = 1'($urandom);
        if ($urandom % 8 == 0) return {s, 23'b0};
        return {s, 7'(58 + $urandom % 14), 16'($urandom)};
    endfunction

    // One cycle: apply inputs, predict, then sample at the next falling edge.
    task automatic step(input bit v, input logic [1:0] f, input logic [3:0] m,
                        input logic [2:0] ox, input logic [2:0] oy,
                        input logic [95:0] a, input logic [95:0] b);
        logic [95:0] ev;
        logic [3:0]  ew;
        logic [1:0]  ec;
        logic [AW-1:0] ex, ey;
        bit eb;
        real ra, rb;
        in_valid = v; in_form = f; in_mask = m; in_opx = ox; in_opy = oy;
        in_src1 = a; in_src2 = b;
        ev = '0; ew = '0; ec = m_cond; ex = m_ax; ey = m_ay; eb = 0;
        if (v) begin
            if (f <= 2'd1) begin
                for (int i = 0; i < 4; i++) begin
                    if (m[i]) begin
                        ew[i] = 1'b1;
                        ra = f2r(a[i*24 +: 24]);
                        rb = f2r(b[i*24 +: 24]);
                        if ((f == 2'd0) ? (ra >= rb) : (ra < rb)) ev[i*24 +: 24] = 24'h3F0000;
                    end
                end
            end else if (f == 2'd2) begin
                if (ox < 3'd6) ec[0] = relop(int'(ox), f2r(a[23:0]), f2r(b[23:0]));
                else eb = 1;
                if (oy < 3'd6) ec[1] = relop(int'(oy), f2r(a[47:24]), f2r(b[47:24]));
                else eb = 1;
            end else begin
                if (m[0]) ex = AW'(to_i(f2r(a[23:0])));
                if (m[1]) ey = AW'(to_i(f2r(a[47:24])));
            end
        end
        @(negedge clk);
        chk("R10 out_valid", {95'b0, out_valid}, {95'b0, v});
        chk((v && f == 2'd0) ? "R1 out_vec" : (v && f == 2'd1) ? "R2 out_vec" : "R3 out_vec",
            out_vec, ev);
        chk("R3 out_wen", {92'b0, out_wen}, {92'b0, ew});
        chk((v && f == 2'd2) ? "R5 cond" : "R9 cond", {94'b0, cond}, {94'b0, ec});
        chk((v && f == 2'd3) ? "R7 addr_x" : "R9 addr_x", {88'b0, addr_x}, {88'b0, ex});
        chk((v && f == 2'd3) ? "R7 addr_y" : "R9 addr_y", {88'b0, addr_y}, {88'b0, ey});
        chk("R6 bad_op", {95'b0, bad_op}, {95'b0, eb});
        m_cond = ec; m_ax = ex; m_ay = ey;
    endtask

    localparam logic [23:0] P1  = 24'h3F0000; // 1.0
    localparam logic [23:0] N1  = 24'hBF0000; // -1.0
    localparam logic [23:0] P2  = 24'h400000; // 2.0
    localparam logic [23:0] PZ  = 24'h000000; // +0
    localparam logic [23:0] NZ  = 24'h800000; // -0
    localparam logic [23:0] P375 = 24'h40E000; // 3.75
    localparam logic [23:0] N55 = 24'hC16000; // -5.5
    localparam logic [23:0] P300 = 24'h472C00; // 300.0
    localparam logic [23:0] N25 = 24'hC04000; // -2.5
    localparam logic [23:0] P075 = 24'h3E8000; // 0.75
    localparam logic [23:0] N200 = 24'hC69000; // -200.0

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset valid", {95'b0, out_valid}, 96'b0);
        chk("R10 reset vec", out_vec, 96'b0);
        chk("R10 reset cond/addr", {78'b0, cond, addr_x, addr_y}, 96'b0);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, '0, '0);

        // R1 with R4 (+0 vs -0 in lane 2)
        step(1, 2'd0, 4'hF, 0, 0, v4(P1, N1, PZ, P375), v4(P1, P2, NZ, N55));
        step(1, 2'd1, 4'hF, 0, 0, v4(P1, N1, PZ, P375), v4(P1, P2, NZ, N55));
        // R4: -0 >= +0 lane 0, -5.5 < -1.0 lane 1
        step(1, 2'd0, 4'h3, 0, 0, v4(NZ, N55, P1, P1), v4(PZ, N1, P1, P1));
        chk("R4 signed zero", out_vec[23:0], P1);
        // R3 partial mask
        step(1, 2'd0, 4'h5, 0, 0, v4(P2, P2, P2, P2), v4(P1, P1, P1, P1));
        step(0, 2'd0, 4'hF, 0, 0, v4(P2, P2, P2, P2), v4(P1, P1, P1, P1));
        // R5: equal on lane 0, less-than on lane 1
        step(1, 2'd2, 4'h0, 3'd0, 3'd2, v4(P1, N1, PZ, PZ), v4(P1, P2, PZ, PZ));
        for (int ox = 0; ox < 8; ox++)
            for (int oy = 0; oy < 8; oy++)
                step(1, 2'd2, 4'h0, 3'(ox), 3'(oy), v4(PZ, N55, P1, P1), v4(NZ, N1, P1, P1));
        // R6
        step(1, 2'd2, 4'h0, 3'd6, 3'd1, v4(P2, P1, PZ, PZ), v4(P1, P1, PZ, PZ));
        step(1, 2'd2, 4'h0, 3'd3, 3'd7, v4(P1, P2, PZ, PZ), v4(P1, P1, PZ, PZ));
        // R7 saturation and truncation
        step(1, 2'd3, 4'h3, 0, 0, v4(P300, N25, PZ, PZ), '0);
        step(1, 2'd3, 4'h1, 0, 0, v4(P075, N200, PZ, PZ), '0);
        step(1, 2'd3, 4'hE, 0, 0, v4(P375, N200, PZ, PZ), '0);
        // R8: mask bits 2,3 alone change nothing
        step(1, 2'd3, 4'hC, 0, 0, v4(P375, P375, P375, P375), '0);
        chk("R8 addr_x kept", {88'b0, addr_x}, 96'd0);
        chk("R8 addr_y kept", {88'b0, addr_y}, {88'b0, 8'h80});

        for (int n = 0; n < 600; n++) begin
            logic [95:0] a, b;
            for (int i = 0; i < 4; i++) begin
                a[i*24 +: 24] = rnd_fp();
                b[i*24 +: 24] = ($urandom % 4 == 0) ? a[i*24 +: 24] : rnd_fp();
            end
            step(($urandom % 8) != 0, 2'($urandom), 4'($urandom), 3'($urandom), 3'($urandom), a, b);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule